// File: doc/BRIEF.md
# Four-channel chained reload timer

The block holds four 16-bit up-counters behind a small synchronous register port. Each channel has a write-only reload value, a live count that can be read back, and a control halfword. The control halfword picks a clock divide ratio, a chain mode, an interrupt enable and a run enable. When a counter wraps past its top value, it reloads. It can also pulse its own interrupt line. When the next channel is in chain mode, the wrap advances that channel by one.

Channels 0 and 1 also drive a one-cycle overflow strobe for a downstream sample consumer. A single shared 10-bit divider provides the divide ratios. Software starts a channel by setting run enable. It pauses a channel by clearing run enable or by moving the channel into chain mode, and it resumes the channel by taking chain mode away again.

Top module: `tmr_quad_chain`

## Requirements
- R1: `addr_i[3:2]` selects the channel. Within a channel's 32-bit word, bits 15:0 hold the count/reload register and bits 31:16 hold control. `size_i` is 0 for a byte, 1 for a halfword and 2 for a word, and write data sits on the lanes given by `addr_i[1:0]`. For a read with `req_i` high and `we_i` low, `rdata_o` shows the whole addressed word one cycle later, with the count taken before that edge.
- R2: A write to the low halfword changes only the reload value; a read of that halfword returns the live count.
- R3: Control layout is bits 1:0 divide select, bit 2 chain mode, bit 6 interrupt enable and bit 7 run enable. Every other control bit reads as zero.
- R4: On a control write that takes run enable from 0 to 1, the count is loaded from the reload value. Counting then starts on the next edge.
- R5: Divide select 0, 1, 2 and 3 advance a free-running channel every 1, 64, 256 and 1024 clocks. The shared divider clears whenever any channel starts, so the first step comes exactly that many edges after the start write.
- R6: Clearing run enable freezes the count at the value it has reached. A later start reloads it.
- R7: Setting chain mode while running freezes the count. Clearing chain mode again, with run enable still set, resumes counting from the frozen value with no reload.
- R8: A channel in chain mode ignores the divider and advances by one only on the cycle its predecessor wraps. Its own wrap passes on to the next channel in that same cycle, so a whole chain can wrap at once.
- R9: Channel 0 ignores its chain-mode bit and always counts from the divider.
- R10: A wrap from 0xFFFF reloads the count. If interrupt enable is set, the channel's `irq_o` bit is high for exactly the one cycle after that edge; with interrupt enable clear it stays low.
- R11: A wrap of channel 0 or 1 drives `dreq_o[0]` or `dreq_o[1]` high for the one cycle after that edge, whatever the interrupt enable says.
- R12: Byte writes merge the new byte into the existing halfword before it takes effect. The low register merges into the reload value and the high register merges into the current control value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte address within the timer block |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Write data, lane aligned |
| rdata_o | output | 32 | Read word, valid the cycle after the request |
| irq_o | output | 4 | Per-channel interrupt pulses |
| dreq_o | output | 2 | Overflow strobes of channels 0 and 1 |

## Verification
A write takes effect at the edge that samples it. A start loads the count at that edge, and a free-running channel at divide N first steps N edges later. Read data appears after the edge that samples the request and reflects the count held before that edge. Interrupt and overflow strobes are registered, so they are high in the cycle after the wrapping edge. The bench therefore counts edges from every write, samples reads at the following falling edge, and samples pulses one time unit after the edge where they are due. For example, a read issued right after a start returns the reload value, and the next read returns the reload value plus one.

// File: rtl/tmr_quad_pkg.sv
package tmr_quad_pkg;
  localparam int unsigned NUM_TMR  = 4;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned CTRL_W   = 16;
  localparam int unsigned BUS_W    = CNT_W + CTRL_W;
  localparam int unsigned BE_W     = BUS_W / 8;
  localparam int unsigned SEL_W    = $clog2(NUM_TMR);
  localparam int unsigned ADDR_W   = SEL_W + $clog2(BE_W);
  localparam int unsigned PSC_W    = 10;
  localparam int unsigned NUM_PSC  = 4;
  localparam int unsigned PSEL_W   = $clog2(NUM_PSC);
  localparam int unsigned NUM_DREQ = 2;

  // control bit positions
  localparam int unsigned CB_PSEL = 0;
  localparam int unsigned CB_CASC = 2;
  localparam int unsigned CB_IRQ  = 6;
  localparam int unsigned CB_RUN  = 7;
  localparam logic [CTRL_W-1:0] CTRL_MASK = CTRL_W'(16'h00C7);

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;

  // divider bits that must be all ones for a tap: 0, 6, 8, 10
  function automatic int unsigned tap_bits(input int unsigned sel);
    return (sel == 0) ? 0 : 4 + 2 * sel;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_quad_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  output logic [NUM_PSC-1:0] tick_o
);
  logic [PSC_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_PSC; g++) begin : g_tap
    localparam logic [PSC_W-1:0] MASK = PSC_W'((1 << tap_bits(g)) - 1);
    assign tick_o[g] = (div_q & MASK) == MASK;
    if (g >= 2) begin : g_nest
      a_r5_tap_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o[g] |-> tick_o[g-1]);
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_quad_pkg::*;
#(
  parameter bit CHAIN_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [BE_W-1:0]    be_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic [NUM_PSC-1:0] tick_i,
  input  logic               chain_i,
  output logic [CNT_W-1:0]   count_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic               ovf_o,
  output logic               start_o,
  output logic               irq_o
);
  localparam int unsigned LO_BYTES = CNT_W / 8;
  localparam int unsigned HI_BYTES = CTRL_W / 8;

  logic [CNT_W-1:0]  reload_q, reload_nx, count_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_nx;
  logic              ctrl_wr, casc_eff, inc, irq_q;

  always_comb begin
    reload_nx = reload_q;
    ctrl_nx   = ctrl_q;
    if (wr_i) begin
      for (int b = 0; b < LO_BYTES; b++)
        if (be_i[b]) reload_nx[8*b +: 8] = wdata_i[8*b +: 8];
      for (int b = 0; b < HI_BYTES; b++)
        if (be_i[LO_BYTES+b]) ctrl_nx[8*b +: 8] = wdata_i[CNT_W + 8*b +: 8];
    end
    ctrl_nx = ctrl_nx & CTRL_MASK;
  end

  assign ctrl_wr  = wr_i && (|be_i[BE_W-1:LO_BYTES]);
  assign start_o  = ctrl_wr && !ctrl_q[CB_RUN] && ctrl_nx[CB_RUN];
  assign casc_eff = CHAIN_EN && ctrl_q[CB_CASC];
  assign inc      = ctrl_q[CB_RUN] &&
                    (casc_eff ? chain_i : tick_i[ctrl_q[CB_PSEL +: PSEL_W]]);
  assign ovf_o    = inc && (&count_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      count_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      reload_q <= reload_nx;
      ctrl_q   <= ctrl_nx;
      irq_q    <= ovf_o && ctrl_q[CB_IRQ];
      if (start_o || ovf_o) count_q <= reload_nx;
      else if (inc)         count_q <= count_q + 1'b1;
    end
  end

  assign count_o = count_q;
  assign ctrl_o  = ctrl_q;
  assign irq_o   = irq_q;

  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[CB_RUN] && !start_o) |=> count_q == $past(count_q));

  a_r7_chain_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CB_RUN] && casc_eff && !chain_i) |=> count_q == $past(count_q));

  a_r5_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CB_RUN] && !casc_eff && ctrl_q[CB_PSEL +: PSEL_W] == '0 && !(&count_q))
    |=> count_q == $past(count_q) + CNT_W'(1));
endmodule

// File: rtl/tmr_quad_chain.sv
module tmr_quad_chain
  import tmr_quad_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          size_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  output logic [NUM_TMR-1:0]  irq_o,
  output logic [NUM_DREQ-1:0] dreq_o
);
  localparam int unsigned OFS_W = ADDR_W - SEL_W;

  logic [SEL_W-1:0]   sel;
  logic [OFS_W-1:0]   ofs;
  logic [BE_W-1:0]    be;
  logic [NUM_PSC-1:0] tick;
  logic [NUM_TMR-1:0] ovf, start, wr;
  logic [CNT_W-1:0]   cnt_a  [NUM_TMR];
  logic [CTRL_W-1:0]  ctrl_a [NUM_TMR];
  logic [BUS_W-1:0]   rdata_q;
  logic [NUM_DREQ-1:0] dreq_q;

  assign sel = addr_i[ADDR_W-1:OFS_W];
  assign ofs = addr_i[OFS_W-1:0];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: be = BE_W'(1) << ofs;
      SZ_HALF: be = BE_W'(3) << {ofs[OFS_W-1], 1'b0};
      default: be = '1;
    endcase
  end

  tmr_prescale u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (|start),
    .tick_o (tick)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
    assign wr[i] = req_i && we_i && (sel == SEL_W'(i));
    tmr_channel #(.CHAIN_EN(i != 0)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr[i]),
      .be_i    (be),
      .wdata_i (wdata_i),
      .tick_i  (tick),
      .chain_i ((i == 0) ? 1'b0 : ovf[(i == 0) ? 0 : i-1]),
      .count_o (cnt_a[i]),
      .ctrl_o  (ctrl_a[i]),
      .ovf_o   (ovf[i]),
      .start_o (start[i]),
      .irq_o   (irq_o[i])
    );
    if (i > 0) begin : g_chk
      a_r8_chain_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf[i] && ctrl_a[i][CB_CASC]) |-> ovf[i-1]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      dreq_q  <= '0;
    end else begin
      dreq_q <= ovf[NUM_DREQ-1:0];
      if (req_i && !we_i) rdata_q <= {ctrl_a[sel], cnt_a[sel]};
    end
  end

  assign rdata_o = rdata_q;
  assign dreq_o  = dreq_q;
endmodule

// File: tb/tmr_quad_chain_tb_top.sv
module tmr_quad_chain_tb_top;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic [1:0]  dreq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_quad_chain dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .dreq_o(dreq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; size = sz; wdata = d << (8 * a[1:0]);
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int ch, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = 4'(ch * 4); size = 2'd2;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic stop_all();
    for (int c = 0; c < 4; c++) wr(4'(c * 4), 2'd2, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int c = 0; c < 4; c++) begin
      rd(c, d);
      chk("R1 reset word", d, 32'h0);
    end
    chk("R10 reset irq", {28'h0, irq}, 32'h0);
    chk("R11 reset dreq", {30'h0, dreq}, 32'h0);
  endtask

  task automatic t_reload_hidden();
    logic [31:0] d;
    wr(4'h4, 2'd1, 32'hABCD);
    rd(1, d);
    chk("R2 low write leaves count", d, 32'h0);
    wr(4'h6, 2'd1, 32'h0083);
    rd(1, d);
    chk("R4 start loads reload", d, 32'h0083_ABCD);
    stop_all();
  endtask

  task automatic t_start_count();
    logic [31:0] d;
    wr(4'h0, 2'd2, 32'h0080_1234);
    rd(0, d);
    chk("R4 count after start", d[15:0], 32'h1234);
    rd(0, d);
    chk("R4 first step", d[15:0], 32'h1235);
    stop_all();
  endtask

  task automatic t_period(input logic [1:0] ps, input int n);
    logic [31:0] d;
    wr(4'h8, 2'd2, {16'h0080 | 16'(ps), 16'h0000});
    repeat (n - 1) @(negedge clk);
    rd(2, d);
    chk($sformatf("R5 div sel %0d before step", ps), d[15:0], 32'h0);
    rd(2, d);
    chk($sformatf("R5 div sel %0d at step", ps), d[15:0], 32'h1);
    wr(4'hA, 2'd1, 32'h0);
  endtask

  task automatic t_freeze();
    logic [31:0] d;
    wr(4'h0, 2'd2, 32'h0080_0100);
    rd(0, d);
    chk("R6 started", d[15:0], 32'h0100);
    wr(4'h2, 2'd1, 32'h0000);
    rd(0, d);
    chk("R6 frozen", d[15:0], 32'h0102);
    repeat (5) @(negedge clk);
    rd(0, d);
    chk("R6 still frozen", d[15:0], 32'h0102);
    wr(4'h2, 2'd1, 32'h0080);
    rd(0, d);
    chk("R6 restart reloads", d[15:0], 32'h0100);
    stop_all();
  endtask

  task automatic t_chain_pause();
    logic [31:0] d;
    wr(4'h4, 2'd2, 32'h0080_0010);
    rd(1, d);
    chk("R7 started", d[15:0], 32'h0010);
    wr(4'h6, 2'd1, 32'h0084);
    rd(1, d);
    chk("R7 chain set freezes", d[15:0], 32'h0012);
    repeat (4) @(negedge clk);
    rd(1, d);
    chk("R7 held", d[15:0], 32'h0012);
    wr(4'h6, 2'd1, 32'h0080);
    rd(1, d);
    chk("R7 resume no reload", d[15:0], 32'h0012);
    rd(1, d);
    chk("R7 resume steps", d[15:0], 32'h0013);
    stop_all();
  endtask

  task automatic t_chain_ripple();
    logic [31:0] d;
    wr(4'hC, 2'd2, 32'h0084_0005);
    wr(4'h8, 2'd2, 32'h00C4_FFFF);
    wr(4'h4, 2'd2, 32'h00C4_FFFF);
    wr(4'h0, 2'd2, 32'h00C0_FFFE);
    @(posedge clk); #1;
    chk("R10 no irq before wrap", {28'h0, irq}, 32'h0);
    @(posedge clk); #1;
    chk("R8 R10 ripple irq", {28'h0, irq}, 32'h7);
    chk("R11 dreq both", {30'h0, dreq}, 32'h3);
    @(posedge clk); #1;
    chk("R10 irq one cycle", {28'h0, irq}, 32'h0);
    chk("R11 dreq one cycle", {30'h0, dreq}, 32'h0);
    @(negedge clk);
    wr(4'h2, 2'd1, 32'h0);
    rd(3, d);
    chk("R8 end of chain", d, 32'h0084_0007);
    rd(1, d);
    chk("R10 wrapped reload", d[15:0], 32'hFFFF);
    rd(0, d);
    chk("R10 first reload", d[15:0], 32'hFFFE);
    stop_all();
  endtask

  task automatic t_first_ignores_chain();
    logic [31:0] d;
    wr(4'h0, 2'd2, 32'h0084_FFFF);
    @(posedge clk); #1;
    chk("R9 ch0 wraps with chain bit", {30'h0, dreq}, 32'h1);
    chk("R10 irq off stays low", {28'h0, irq}, 32'h0);
    @(negedge clk);
    rd(0, d);
    chk("R9 ch0 control kept", d, 32'h0084_FFFF);
    stop_all();
  endtask

  task automatic t_byte_merge();
    logic [31:0] d;
    wr(4'hC, 2'd2, 32'h0000_1122);
    wr(4'hD, 2'd0, 32'h77);
    wr(4'hE, 2'd0, 32'h81);
    wr(4'hF, 2'd0, 32'hFF);
    rd(3, d);
    chk("R12 R3 byte merge", d, 32'h0081_7722);
    wr(4'hC, 2'd1, 32'h5555);
    rd(3, d);
    chk("R2 reload write hidden", d, 32'h0081_7722);
    stop_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reload_hidden();
    t_start_count();
    t_period(2'd0, 1);
    t_period(2'd1, 64);
    t_period(2'd2, 256);
    t_period(2'd3, 1024);
    t_freeze();
    t_chain_pause();
    t_chain_ripple();
    t_first_ignores_chain();
    t_byte_merge();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule